// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Every lane sends seven bits in each pixel period. All logic runs on a bit clock at seven times the pixel rate. The pixel clock comes in as an ordinary input and is sampled on that bit clock. A selectable edge of the pixel clock captures the parallel word into a holding register.

A frame-start strobe loads the held word into four 7-bit shift registers at the same time. Each shift register takes its own fixed, scrambled subset of the input bits. The registers then shift out one bit per bit-clock cycle. The forwarded clock lane repeats a 7-slot pattern of four high slots and three low slots. The first high slot lines up with the first bit of every lane.

An active-low power-down input silences every output and clears the internal state. After power-down is released, output starts again only at the next frame-start strobe.

Top module: `pixlink_serializer`

## Requirements
- R1: After reset, every lane output and the clock lane are 0.
- R2: With edge_sel high, the word present on pix_data when pix_clk is seen rising is captured; a change of pix_data before the following fall has no effect.
- R3: With edge_sel low, the word present on pix_data when pix_clk is seen falling is captured; the value at the preceding rise is not kept.
- R4: Lane 0 sends input bits 7, 6, 4, 3, 2, 1, 0 in slots 0 to 6. Slot 0 is the cycle right after the load edge.
- R5: Lane 1 sends input bits 18, 15, 14, 13, 12, 9, 8 in slots 0 to 6.
- R6: Lane 2 sends input bits 26, 25, 24, 22, 21, 20, 19 in slots 0 to 6.
- R7: Lane 3 sends input bits 23, 17, 16, 11, 10, 5, 27 in slots 0 to 6.
- R8: The clock lane is 1 in slots 0 to 3 and 0 in slots 4 to 6. Slot 0 is shared by all lanes and begins one bit clock after frame_start is sampled high.
- R9: If no new frame_start arrives after slot 6, the clock pattern keeps repeating every 7 cycles and the data lanes send 0.
- R10: While pd_n is low, all outputs are 0 from the next cycle on. The shift registers and the held word are cleared, and frame_start is ignored.
- R11: After pd_n returns high, all outputs stay 0 until a frame_start is sampled. A frame loaded before any new capture sends all-zero data.
- R12: A frame_start in the middle of a word restarts every lane and the clock lane at slot 0 with the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; the link runs only when this is high |
| edge_sel | input | 1 | Capture edge select: 1 = rising, 0 = falling |
| pix_clk | input | 1 | Pixel clock, sampled on clk_bit |
| frame_start | input | 1 | Strobe that loads all lanes and restarts the slot count |
| pix_data | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane | output | 1 | Forwarded clock pattern, 4 high / 3 low |

## Verification
The bench drives a different word at each pixel-clock edge. A design that used the wrong edge would send the other word, in every lane at once.

Walking-one words cover each of the 28 input bits. A swapped lane assignment or a reversed bit order would show the single 1 in the wrong lane or the wrong slot.

Three further cases are covered:
- A missing strobe: a design that reloaded on its own would repeat stale data.
- A strobe in the middle of a word: a design that ignored it would stay misaligned with the restarted clock pattern.
- Power-down with strobes applied during it: a design that kept the held word, or started without a new strobe, would put non-zero data on the lanes.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

    localparam int LANES      = 4;
    localparam int SLOTS      = 7;
    localparam int WORD       = LANES * SLOTS;
    localparam int HIGH_SLOTS = 4;

    // Source bit of the parallel word for each lane and slot (slot 0 sent first)
    localparam int SRC_MAP [LANES][SLOTS] = '{
        '{ 7,  6,  4,  3,  2,  1,  0},
        '{18, 15, 14, 13, 12,  9,  8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10,  5, 27}
    };

endpackage

// File: rtl/pixlink_capture.sv
module pixlink_capture #(
    parameter int WORD = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_n,
    input  logic            pix_clk,
    input  logic            edge_sel,
    input  logic [WORD-1:0] data_in,
    output logic [WORD-1:0] hold_o
);

    typedef struct packed {
        logic            pix;
        logic [WORD-1:0] hold;
    } cap_t;

    cap_t st_d, st_q;
    logic rise, fall, hit;

    always_comb begin
        st_d     = st_q;
        st_d.pix = pix_clk;
        rise     = pix_clk & ~st_q.pix;
        fall     = ~pix_clk & st_q.pix;
        hit      = edge_sel ? rise : fall;
        if (!pd_n) begin
            st_d.hold = '0;
        end else if (hit) begin
            st_d.hold = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/pixlink_lane.sv
module pixlink_lane #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             load,
    input  logic [SLOTS-1:0] image_i,
    output logic             ser_o
);

    typedef struct packed {
        logic [SLOTS-1:0] sh;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pd_n) begin
            st_d.sh = '0;
        end else if (load) begin
            st_d.sh = image_i;
        end else begin
            st_d.sh = {st_q.sh[SLOTS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.sh[SLOTS-1];

endmodule

// File: rtl/pixlink_clkpat.sv
module pixlink_clkpat #(
    parameter int SLOTS = 7,
    parameter int HIGH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic start,
    output logic clk_o
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] HIGH_END  = SLOT_W'(HIGH);

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
        logic              pat;
    } pat_t;

    pat_t st_d, st_q;
    logic [SLOT_W-1:0] nslot;

    always_comb begin
        st_d  = st_q;
        nslot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        if (!pd_n) begin
            st_d = '0;
        end else if (start) begin
            st_d.run  = 1'b1;
            st_d.slot = '0;
            st_d.pat  = 1'b1;
        end else if (st_q.run) begin
            st_d.slot = nslot;
            st_d.pat  = (nslot < HIGH_END);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.pat;

endmodule

// File: rtl/pixlink_serializer.sv
module pixlink_serializer
    import pixlink_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int N_SLOTS = SLOTS,
    parameter int N_HIGH  = HIGH_SLOTS
) (
    input  logic                       clk_bit,
    input  logic                       rst_n,
    input  logic                       pd_n,
    input  logic                       edge_sel,
    input  logic                       pix_clk,
    input  logic                       frame_start,
    input  logic [N_LANES*N_SLOTS-1:0] pix_data,
    output logic [N_LANES-1:0]         lane_out,
    output logic                       clk_lane
);

    localparam int N_WORD = N_LANES * N_SLOTS;

    logic [N_WORD-1:0] held;

    pixlink_capture #(.WORD(N_WORD)) u_cap (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .pix_clk  (pix_clk),
        .edge_sel (edge_sel),
        .data_in  (pix_data),
        .hold_o   (held)
    );

    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        logic [N_SLOTS-1:0] image;

        // Slot 0 goes to the MSB so that it leaves first
        always_comb begin
            for (int s = 0; s < N_SLOTS; s++) begin
                image[N_SLOTS-1-s] = held[SRC_MAP[ln][s]];
            end
        end

        pixlink_lane #(.SLOTS(N_SLOTS)) u_lane (
            .clk     (clk_bit),
            .rst_n   (rst_n),
            .pd_n    (pd_n),
            .load    (frame_start),
            .image_i (image),
            .ser_o   (lane_out[ln])
        );
    end

    pixlink_clkpat #(.SLOTS(N_SLOTS), .HIGH(N_HIGH)) u_pat (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .pd_n  (pd_n),
        .start (frame_start),
        .clk_o (clk_lane)
    );

endmodule

// File: rtl/pixlink_serializer_chk.sv
module pixlink_serializer_chk #(
    parameter int N_LANES = 4,
    parameter int N_SLOTS = 7,
    parameter int N_HIGH  = 4
) (
    input logic               clk_bit,
    input logic               rst_n,
    input logic               pd_n,
    input logic               frame_start,
    input logic [N_LANES-1:0] lane_out,
    input logic               clk_lane
);

    localparam int CW    = $clog2(N_SLOTS + 2);
    localparam int N_LOW = N_SLOTS - N_HIGH;

    logic          started_q;
    logic [CW-1:0] hi_prev_q, lo_prev_q;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            hi_prev_q <= '0;
            lo_prev_q <= '0;
        end else begin
            if (!pd_n) begin
                started_q <= 1'b0;
            end else if (frame_start) begin
                started_q <= 1'b1;
            end
            if (!pd_n || frame_start || !clk_lane) begin
                hi_prev_q <= '0;
            end else if (hi_prev_q != '1) begin
                hi_prev_q <= hi_prev_q + 1'b1;
            end
            if (!pd_n || frame_start || !started_q || clk_lane) begin
                lo_prev_q <= '0;
            end else if (lo_prev_q != '1) begin
                lo_prev_q <= lo_prev_q + 1'b1;
            end
        end
    end

    AST_PD_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pd_n |=> (lane_out == '0 && !clk_lane)); // R10

    AST_IDLE_UNTIL_START: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !started_q |-> (lane_out == '0 && !clk_lane)); // R11

    AST_START_CLK_HIGH: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (frame_start && pd_n) |=> clk_lane); // R12

    AST_CLK_HIGH_MAX: assert property (@(posedge clk_bit) disable iff (!rst_n)
        clk_lane |-> (hi_prev_q < CW'(N_HIGH))); // R8

    AST_CLK_LOW_MAX: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (started_q && !clk_lane) |-> (lo_prev_q < CW'(N_LOW))); // R9

endmodule

bind pixlink_serializer pixlink_serializer_chk #(
    .N_LANES (N_LANES),
    .N_SLOTS (N_SLOTS),
    .N_HIGH  (N_HIGH)
) u_chk (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .pd_n        (pd_n),
    .frame_start (frame_start),
    .lane_out    (lane_out),
    .clk_lane    (clk_lane)
);

// File: tb/pixlink_serializer_test.sv
module pixlink_serializer_test;

    logic        clk_bit = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        edge_sel = 1'b0;
    logic        pix_clk = 1'b0;
    logic        frame_start = 1'b0;
    logic [27:0] pix_data = '0;
    logic [3:0]  lane_out;
    logic        clk_lane;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected slot order per lane, written from R4..R7
    int exp_map [4][7] = '{
        '{ 7,  6,  4,  3,  2,  1,  0},
        '{18, 15, 14, 13, 12,  9,  8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10,  5, 27}
    };
    string lane_req [4] = '{"R4", "R5", "R6", "R7"};

    pixlink_serializer uut (
        .clk_bit     (clk_bit),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .edge_sel    (edge_sel),
        .pix_clk     (pix_clk),
        .frame_start (frame_start),
        .pix_data    (pix_data),
        .lane_out    (lane_out),
        .clk_lane    (clk_lane)
    );

    always #2 clk_bit = ~clk_bit;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string req, input string what);
        check(req, {what, " lanes"}, int'(lane_out), 0);
        check(req, {what, " clock"}, int'(clk_lane), 0);
    endtask

    // Two pixel-clock edges: word a at the rise, word b at the fall
    task automatic capture(input logic [27:0] a, input logic [27:0] b);
        @(negedge clk_bit);
        pix_data = a;
        pix_clk  = 1'b1;
        @(negedge clk_bit);
        pix_data = b;
        pix_clk  = 1'b0;
        @(negedge clk_bit);
    endtask

    // Strobe, then compare all 7 slots of every lane and the clock lane
    task automatic frame_check(input logic [27:0] w, input string ctx);
        @(negedge clk_bit);
        frame_start = 1'b1;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk_bit);
            frame_start = 1'b0;
            for (int l = 0; l < 4; l++) begin
                check(lane_req[l], $sformatf("%s lane%0d slot%0d", ctx, l, k),
                      int'(lane_out[l]), int'(w[exp_map[l][k]]));
            end
            check("R8", $sformatf("%s clock slot%0d", ctx, k), int'(clk_lane), (k < 4) ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk_bit);
        check_quiet("R1", "reset");
        rst_n = 1'b1;
        @(negedge clk_bit);
        check_quiet("R1", "after reset");
    endtask

    task automatic t_rise();
        edge_sel = 1'b1;
        capture(28'h9A5_3C71, 28'h0F0_F0F0);
        frame_check(28'h9A5_3C71, "R2 rising");
    endtask

    task automatic t_fall();
        edge_sel = 1'b0;
        capture(28'h123_4567, 28'hE5B_9C2D);
        frame_check(28'hE5B_9C2D, "R3 falling");
    endtask

    task automatic t_walk();
        edge_sel = 1'b1;
        for (int i = 0; i < 28; i++) begin
            capture(28'(1) << i, 28'h0);
            frame_check(28'(1) << i, $sformatf("walk bit%0d", i));
        end
    endtask

    task automatic t_no_start();
        // R9: after slot 6 with no strobe
        edge_sel = 1'b1;
        capture(28'hFFF_FFFF, 28'hFFF_FFFF);
        frame_check(28'hFFF_FFFF, "R9 setup");
        for (int k = 0; k < 14; k++) begin
            @(negedge clk_bit);
            check("R9", $sformatf("free lanes %0d", k), int'(lane_out), 0);
            check("R9", $sformatf("free clock %0d", k), int'(clk_lane), ((k % 7) < 4) ? 1 : 0);
        end
    endtask

    task automatic t_restart();
        // R12: strobe after slot 2 restarts at slot 0
        edge_sel = 1'b1;
        capture(28'hB6D_5A3E, 28'h0);
        @(negedge clk_bit);
        frame_start = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_bit);
            frame_start = 1'b0;
            check("R12", $sformatf("pre-restart clock slot%0d", k), int'(clk_lane), 1);
        end
        frame_check(28'hB6D_5A3E, "R12 restart");
    endtask

    task automatic t_power_down();
        edge_sel = 1'b1;
        capture(28'hFFF_FFFF, 28'h0);
        @(negedge clk_bit);
        frame_start = 1'b1;
        @(negedge clk_bit);
        frame_start = 1'b0;
        @(negedge clk_bit);
        pd_n = 1'b0;
        @(negedge clk_bit);
        check_quiet("R10", "pd entry");
        frame_start = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_bit);
            check_quiet("R10", $sformatf("pd strobe %0d", k));
        end
        frame_start = 1'b0;
        pd_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk_bit);
            check_quiet("R11", $sformatf("released idle %0d", k));
        end
        frame_check(28'h0, "R11 cleared hold");
        capture(28'h5C3_A1E7, 28'h0);
        frame_check(28'h5C3_A1E7, "R11 resumed");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_walk();
        t_no_start();
        t_restart();
        t_power_down();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule